// File: doc/BRIEF.md
# Separable Two-Pass Fractional Pixel Interpolator

This block computes a fractionally shifted prediction block from an 8-bit reference patch using two separable FIR passes. Reference pixels arrive one per cycle in raster order under a valid/ready handshake. A pipelined horizontal filter turns each incoming row into a row of horizontally interpolated values. Those values are kept at full signed precision, without clipping, in a cascade of TAPS-1 row buffers. For every column the vertical pass takes the new horizontal value together with the TAPS-1 older values held for that column. It forms TAPS products at once, sums them in an adder tree, and only then rounds, shifts and clips to an 8-bit pixel.

A block starts with a one-cycle `start` pulse while the controller is idle. The horizontal and vertical fractional phases are captured on that pulse. The block then accepts (OUT_W+TAPS-1) x (OUT_H+TAPS-1) reference pixels and emits OUT_W x OUT_H interpolated pixels, then signals completion. The controller has four states. IDLE goes to RUN on `start`. RUN goes to DRAIN when the last reference pixel is accepted. DRAIN goes to DONE in the cycle the last output pixel is presented. DONE always returns to IDLE after one cycle. The row buffers need no clearing between blocks, because the row counter restarts on each `start` and the first TAPS-1 rows of every block only load the buffers. TAPS=8 selects the luma coefficient set with a 2-bit phase, and TAPS=4 selects the chroma set with a 3-bit phase.

Top module: `interp_2d`

## Requirements
- R1: After reset `in_ready`, `out_valid` and `block_done` are all low and the block waits in IDLE.
- R2: A `start` pulse in IDLE makes `in_ready` high from the next cycle. It stays high until exactly (OUT_W+TAPS-1)*(OUT_H+TAPS-1) pixels have been accepted, and is low in the cycle after the last one.
- R3: The horizontal value for output column x of input row y is the sum over k of C[frac_h][k] times pixel (x+k, y). This value is kept as a signed 16-bit number, unclipped and unshifted.
- R4: Input rows 0 to TAPS-2 of a block produce no output. Output (x, y) is clip(((sum over k of C[frac_v][k] times h(x, y+k)) + 2048) >>> 12), so both 6-bit coefficient scalings are removed in a single rounded shift at the end.
- R5: The luma table (TAPS=8) is: phase 0 {0,0,0,64,0,0,0,0}, phase 1 {-1,4,-10,58,17,-5,1,0}, phase 2 {-1,4,-11,40,40,-11,4,-1} and phase 3 {0,1,-5,17,58,-10,4,-1}. Coefficient k multiplies column x+k (horizontal) or row y+k (vertical). The chroma table (TAPS=4) has phases 0 to 7: {0,64,0,0}, {-2,58,10,-2}, {-4,54,16,-2}, {-6,46,28,-4}, {-4,36,36,-4}, {-4,28,46,-6}, {-2,16,54,-4} and {-2,10,58,-2}.
- R6: Outputs appear in raster order, one per accepted pixel at column at least TAPS-1 of a row at least TAPS-1. Exactly OUT_W*OUT_H outputs are produced per block.
- R7: A rounded result below 0 is output as 0 and one above 255 is output as 255.
- R8: Changes on `frac_h` and `frac_v` after the `start` pulse have no effect on the block in progress.
- R9: `block_done` is high for exactly one cycle, the cycle after the last output pixel. A following block is computed only from its own pixels.
- R10: `in_valid` is ignored outside RUN (no output, `in_ready` low), and idle gaps in `in_valid` during RUN do not change the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a block when idle; captures the phases |
| frac_h | input | PH_W | Horizontal fractional phase |
| frac_v | input | PH_W | Vertical fractional phase |
| in_valid | input | 1 | Reference pixel valid |
| in_ready | output | 1 | Block accepts a reference pixel |
| in_pix | input | 8 | Reference pixel, unsigned |
| out_valid | output | 1 | Interpolated pixel valid |
| out_pix | output | 8 | Interpolated pixel, unsigned |
| block_done | output | 1 | One-cycle pulse after the last output |

## Verification
The embedded properties assume that the phase inputs hold legal codes for the chosen tap count. They also assume that `start` is pulsed only after the previous block has returned to IDLE, and that pixels are 8-bit unsigned values, so the horizontal bound holds. The stimulus draws phases only from the legal table range and issues `start` only after `block_done` has been seen. It mixes gradient, checkerboard and random images, with and without gaps in `in_valid`, so every value it applies stays inside those assumptions.

// File: rtl/interp_pkg.sv
package interp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2,
        ST_DONE  = 2'd3
    } ip_state_t;

    localparam int COEF_FRAC = 6;

    // Coefficient k of phase ph for an n-tap filter (8 = luma, 4 = chroma).
    function automatic logic signed [7:0] tap_coef(int n, int ph, int k);
        logic signed [7:0] t [8];
        t = '{default: 8'sd0};
        if (n == 8) begin
            unique case (ph)
                0:       t = '{8'sd0, 8'sd0, 8'sd0, 8'sd64, 8'sd0, 8'sd0, 8'sd0, 8'sd0};
                1:       t = '{-8'sd1, 8'sd4, -8'sd10, 8'sd58, 8'sd17, -8'sd5, 8'sd1, 8'sd0};
                2:       t = '{-8'sd1, 8'sd4, -8'sd11, 8'sd40, 8'sd40, -8'sd11, 8'sd4, -8'sd1};
                default: t = '{8'sd0, 8'sd1, -8'sd5, 8'sd17, 8'sd58, -8'sd10, 8'sd4, -8'sd1};
            endcase
        end else begin
            unique case (ph)
                0:       t = '{8'sd0, 8'sd64, 8'sd0, 8'sd0, 8'sd0, 8'sd0, 8'sd0, 8'sd0};
                1:       t = '{-8'sd2, 8'sd58, 8'sd10, -8'sd2, 8'sd0, 8'sd0, 8'sd0, 8'sd0};
                2:       t = '{-8'sd4, 8'sd54, 8'sd16, -8'sd2, 8'sd0, 8'sd0, 8'sd0, 8'sd0};
                3:       t = '{-8'sd6, 8'sd46, 8'sd28, -8'sd4, 8'sd0, 8'sd0, 8'sd0, 8'sd0};
                4:       t = '{-8'sd4, 8'sd36, 8'sd36, -8'sd4, 8'sd0, 8'sd0, 8'sd0, 8'sd0};
                5:       t = '{-8'sd4, 8'sd28, 8'sd46, -8'sd6, 8'sd0, 8'sd0, 8'sd0, 8'sd0};
                6:       t = '{-8'sd2, 8'sd16, 8'sd54, -8'sd4, 8'sd0, 8'sd0, 8'sd0, 8'sd0};
                default: t = '{-8'sd2, 8'sd10, 8'sd58, -8'sd2, 8'sd0, 8'sd0, 8'sd0, 8'sd0};
            endcase
        end
        return t[k];
    endfunction

endpackage

// File: rtl/interp_ctrl.sv
module interp_ctrl
    import interp_pkg::*;
#(
    parameter int TAPS  = 8,
    parameter int OUT_W = 8,
    parameter int OUT_H = 8,
    parameter int PH_W  = 2,
    parameter int CW    = 4,
    parameter int RW    = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [PH_W-1:0] frac_h_in,
    input  logic [PH_W-1:0] frac_v_in,
    input  logic            in_valid,
    input  logic            out_valid,
    output logic            in_ready,
    output logic            acc,
    output logic [CW-1:0]   col,
    output logic [RW-1:0]   row,
    output logic [PH_W-1:0] frac_h,
    output logic [PH_W-1:0] frac_v,
    output logic            block_done
);
    localparam int IN_W  = OUT_W + TAPS - 1;
    localparam int IN_H  = OUT_H + TAPS - 1;
    localparam int TOTAL = OUT_W * OUT_H;
    localparam int OCW   = $clog2(TOTAL + 1);

    ip_state_t      state, state_nx;
    logic [OCW-1:0] out_cnt;
    logic           last_in, last_out;

    assign acc      = in_valid && in_ready;
    assign last_in  = acc && (col == CW'(IN_W - 1)) && (row == RW'(IN_H - 1));
    assign last_out = out_valid && (out_cnt == OCW'(TOTAL - 1));

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start)    state_nx = ST_RUN;
            ST_RUN:   if (last_in)  state_nx = ST_DRAIN;
            ST_DRAIN: if (last_out) state_nx = ST_DONE;
            ST_DONE:                state_nx = ST_IDLE;
            default:                state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        in_ready   = 1'b0;
        block_done = 1'b0;
        unique case (state)
            ST_RUN:  in_ready   = 1'b1;
            ST_DONE: block_done = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col     <= '0;
            row     <= '0;
            out_cnt <= '0;
            frac_h  <= '0;
            frac_v  <= '0;
        end else begin
            if (state == ST_IDLE && start) begin
                col     <= '0;
                row     <= '0;
                out_cnt <= '0;
                frac_h  <= frac_h_in;
                frac_v  <= frac_v_in;
            end
            if (acc) begin
                if (col == CW'(IN_W - 1)) begin
                    col <= '0;
                    row <= row + 1'b1;
                end else begin
                    col <= col + 1'b1;
                end
            end
            if (out_valid) out_cnt <= out_cnt + 1'b1;
        end
    end

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        block_done |=> !block_done);
    a_r6_out_bound: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_cnt < OCW'(TOTAL)));
    a_r8_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && $past(state) != ST_IDLE) |-> ($stable(frac_h) && $stable(frac_v)));
    a_r2_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        block_done |-> !in_ready);
endmodule

// File: rtl/interp_hpass.sv
module interp_hpass
    import interp_pkg::*;
#(
    parameter int TAPS  = 8,
    parameter int OUT_W = 8,
    parameter int PH_W  = 2,
    parameter int CW    = 4,
    parameter int RW    = 4,
    parameter int XW    = 3,
    parameter int HW    = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 acc,
    input  logic [7:0]           pix,
    input  logic [CW-1:0]        col,
    input  logic [RW-1:0]        row,
    input  logic [PH_W-1:0]      frac_h,
    output logic                 h_vld,
    output logic [XW-1:0]        h_col,
    output logic [RW-1:0]        h_row,
    output logic signed [HW-1:0] hval
);
    localparam int HLIM = 255 * ((TAPS == 8) ? 112 : 84);

    logic [7:0]           win [TAPS];
    logic                 t_go;
    logic [XW-1:0]        t_col;
    logic [RW-1:0]        t_row;
    logic signed [HW-1:0] hsum;

    // Stage 1: sliding window of the last TAPS pixels of the row.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < TAPS; k++) win[k] <= '0;
            t_go  <= 1'b0;
            t_col <= '0;
            t_row <= '0;
        end else begin
            t_go <= acc && (col >= CW'(TAPS - 1));
            if (acc) begin
                win[0] <= pix;
                for (int k = 1; k < TAPS; k++) win[k] <= win[k-1];
                t_col <= XW'(col - CW'(TAPS - 1));
                t_row <= row;
            end
        end
    end

    // win[TAPS-1-k] holds column x+k of the window.
    always_comb begin
        hsum = '0;
        for (int k = 0; k < TAPS; k++)
            hsum += HW'(tap_coef(TAPS, int'(frac_h), k)) * HW'($signed({1'b0, win[TAPS-1-k]}));
    end

    // Stage 2: registered horizontal value.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_vld <= 1'b0;
            h_col <= '0;
            h_row <= '0;
            hval  <= '0;
        end else begin
            h_vld <= t_go;
            if (t_go) begin
                h_col <= t_col;
                h_row <= t_row;
                hval  <= hsum;
            end
        end
    end

    a_r3_h_range: assert property (@(posedge clk) disable iff (!rst_n)
        h_vld |-> (hval <= HW'(HLIM) && hval >= -HW'(HLIM)));
endmodule

// File: rtl/interp_vpass.sv
module interp_vpass
    import interp_pkg::*;
#(
    parameter int TAPS  = 8,
    parameter int OUT_W = 8,
    parameter int PH_W  = 2,
    parameter int RW    = 4,
    parameter int XW    = 3,
    parameter int HW    = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 h_vld,
    input  logic [XW-1:0]        h_col,
    input  logic [RW-1:0]        h_row,
    input  logic signed [HW-1:0] hval,
    input  logic [PH_W-1:0]      frac_v,
    output logic                 out_valid,
    output logic [7:0]           out_pix
);
    localparam int SHIFT = 2 * COEF_FRAC;
    localparam int AW    = HW + 8 + $clog2(TAPS) + 1;
    localparam logic signed [AW-1:0] ROUND   = AW'(1) <<< (SHIFT - 1);
    localparam logic signed [AW-1:0] PIX_MAX = AW'(255);

    logic signed [HW-1:0] fifo [TAPS-1][OUT_W];
    logic signed [HW-1:0] rowv [TAPS];
    logic signed [AW-1:0] vmix, vsum, rnd;
    logic                 v_go;

    // Cascade of row buffers: fifo[k] holds the row k+1 above the current one.
    always_ff @(posedge clk) begin
        if (h_vld) begin
            fifo[0][h_col] <= hval;
            for (int k = 1; k < TAPS - 1; k++) fifo[k][h_col] <= fifo[k-1][h_col];
        end
    end

    assign rowv[TAPS-1] = hval;
    for (genvar g = 0; g < TAPS - 1; g++) begin : g_tap
        assign rowv[g] = fifo[TAPS-2-g][h_col];
    end

    always_comb begin
        vmix = '0;
        for (int k = 0; k < TAPS; k++)
            vmix += AW'(tap_coef(TAPS, int'(frac_v), k)) * AW'(rowv[k]);
    end

    assign rnd = (vsum + ROUND) >>> SHIFT;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_go      <= 1'b0;
            vsum      <= '0;
            out_valid <= 1'b0;
            out_pix   <= '0;
        end else begin
            v_go <= h_vld && (h_row >= RW'(TAPS - 1));
            if (h_vld) vsum <= vmix;
            out_valid <= v_go;
            if (v_go) begin
                if (rnd < 0)            out_pix <= 8'd0;
                else if (rnd > PIX_MAX) out_pix <= 8'd255;
                else                    out_pix <= rnd[7:0];
            end
        end
    end

    a_r7_clip_high: assert property (@(posedge clk) disable iff (!rst_n)
        (v_go && rnd > PIX_MAX) |=> (out_valid && out_pix == 8'd255));
    a_r7_clip_low: assert property (@(posedge clk) disable iff (!rst_n)
        (v_go && rnd < 0) |=> (out_valid && out_pix == 8'd0));
endmodule

// File: rtl/interp_2d.sv
module interp_2d
    import interp_pkg::*;
#(
    parameter int TAPS  = 8,
    parameter int OUT_W = 8,
    parameter int OUT_H = 8,
    localparam int PH_W = (TAPS == 8) ? 2 : 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [PH_W-1:0] frac_h,
    input  logic [PH_W-1:0] frac_v,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [7:0]      in_pix,
    output logic            out_valid,
    output logic [7:0]      out_pix,
    output logic            block_done
);
    localparam int CW = $clog2(OUT_W + TAPS - 1);
    localparam int RW = $clog2(OUT_H + TAPS - 1);
    localparam int XW = (OUT_W > 1) ? $clog2(OUT_W) : 1;
    localparam int HW = 16;

    logic                 acc, h_vld;
    logic [CW-1:0]        col;
    logic [RW-1:0]        row, h_row;
    logic [XW-1:0]        h_col;
    logic [PH_W-1:0]      ph_h, ph_v;
    logic signed [HW-1:0] hval;

    interp_ctrl #(.TAPS(TAPS), .OUT_W(OUT_W), .OUT_H(OUT_H), .PH_W(PH_W), .CW(CW), .RW(RW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .frac_h_in(frac_h), .frac_v_in(frac_v),
        .in_valid(in_valid), .out_valid(out_valid), .in_ready(in_ready), .acc(acc),
        .col(col), .row(row), .frac_h(ph_h), .frac_v(ph_v), .block_done(block_done)
    );

    interp_hpass #(.TAPS(TAPS), .OUT_W(OUT_W), .PH_W(PH_W), .CW(CW), .RW(RW), .XW(XW), .HW(HW)) u_h (
        .clk(clk), .rst_n(rst_n), .acc(acc), .pix(in_pix), .col(col), .row(row),
        .frac_h(ph_h), .h_vld(h_vld), .h_col(h_col), .h_row(h_row), .hval(hval)
    );

    interp_vpass #(.TAPS(TAPS), .OUT_W(OUT_W), .PH_W(PH_W), .RW(RW), .XW(XW), .HW(HW)) u_v (
        .clk(clk), .rst_n(rst_n), .h_vld(h_vld), .h_col(h_col), .h_row(h_row), .hval(hval),
        .frac_v(ph_v), .out_valid(out_valid), .out_pix(out_pix)
    );

    a_r10_no_out_idle_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && block_done) == 1'b0);
endmodule

// File: tb/sim_interp_2d.sv
`timescale 1ns/1ps
module sim_interp_2d;
    localparam int TAPS  = 8;
    localparam int OUT_W = 8;
    localparam int OUT_H = 8;
    localparam int IN_W  = OUT_W + TAPS - 1;
    localparam int IN_H  = OUT_H + TAPS - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [1:0] frac_h = '0, frac_v = '0;
    logic in_valid = 1'b0;
    logic [7:0] in_pix = '0;
    logic in_ready, out_valid, block_done;
    logic [7:0] out_pix;

    always #2.5 clk = ~clk;

    interp_2d #(.TAPS(TAPS), .OUT_W(OUT_W), .OUT_H(OUT_H)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .frac_h(frac_h), .frac_v(frac_v),
        .in_valid(in_valid), .in_ready(in_ready), .in_pix(in_pix),
        .out_valid(out_valid), .out_pix(out_pix), .block_done(block_done)
    );

    int lut [4][8] = '{
        '{0, 0, 0, 64, 0, 0, 0, 0},
        '{-1, 4, -10, 58, 17, -5, 1, 0},
        '{-1, 4, -11, 40, 40, -11, 4, -1},
        '{0, 1, -5, 17, 58, -10, 4, -1}
    };

    int    checks = 0, failures = 0, done_cnt = 0;
    int    q[$];
    string cur_req = "R4";
    bit    prev_out = 1'b0;
    bit    finished = 1'b0;
    int    img [IN_H][IN_W];
    int    hv  [IN_H][OUT_W];

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                if (q.size() == 0) chk(1'b0, {cur_req, " R6 extra output"}, int'(out_pix), -1);
                else begin
                    int e;
                    e = q.pop_front();
                    chk(int'(out_pix) == e, cur_req, int'(out_pix), e);
                end
            end
            if (block_done) begin
                chk(prev_out && q.size() == 0, "R9 done timing", q.size(), 0);
                done_cnt++;
            end
            prev_out = out_valid;
        end
    end

    task automatic fill_img(int pat);
        for (int y = 0; y < IN_H; y++)
            for (int x = 0; x < IN_W; x++)
                unique case (pat)
                    0:       img[y][x] = (x * 13 + y * 7) % 256;
                    1:       img[y][x] = ((x + y) % 2 == 1) ? 255 : 0;
                    default: img[y][x] = int'($urandom_range(0, 255));
                endcase
    endtask

    task automatic push_expected(int ph, int pv);
        for (int y = 0; y < IN_H; y++)
            for (int x = 0; x < OUT_W; x++) begin
                hv[y][x] = 0;
                for (int k = 0; k < TAPS; k++) hv[y][x] += lut[ph][k] * img[y][x+k];
            end
        for (int y = 0; y < OUT_H; y++)
            for (int x = 0; x < OUT_W; x++) begin
                int v;
                v = 0;
                for (int k = 0; k < TAPS; k++) v += lut[pv][k] * hv[y+k][x];
                v = (v + 2048) >>> 12;
                if (v < 0) v = 0;
                if (v > 255) v = 255;
                q.push_back(v);
            end
    endtask

    task automatic run_block(int ph, int pv, int pat, bit gaps, bit wiggle, string req);
        int d0;
        cur_req = req;
        fill_img(pat);
        push_expected(ph, pv);
        d0 = done_cnt;
        @(negedge clk);
        frac_h = 2'(ph); frac_v = 2'(pv); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(in_ready == 1'b1, "R2 ready after start", int'(in_ready), 1);
        for (int y = 0; y < IN_H; y++)
            for (int x = 0; x < IN_W; x++) begin
                if (gaps && ($urandom_range(0, 2) == 0)) begin
                    in_valid = 1'b0;
                    @(negedge clk);
                end
                in_valid = 1'b1;
                in_pix   = 8'(img[y][x]);
                if (wiggle) begin frac_h = 2'($urandom_range(0, 3)); frac_v = 2'($urandom_range(0, 3)); end
                @(negedge clk);
            end
        in_valid = 1'b0;
        chk(in_ready == 1'b0, "R2 ready low after last pixel", int'(in_ready), 0);
        while (done_cnt == d0) @(negedge clk);
        chk(q.size() == 0, "R6 output count", q.size(), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++; checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(in_ready == 1'b0, "R1 in_ready", int'(in_ready), 0);
        chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        chk(block_done == 1'b0, "R1 block_done", int'(block_done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: in_valid while idle is ignored
        in_valid = 1'b1; in_pix = 8'd200;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk(!in_ready && !out_valid, "R10 idle ignore", int'(out_valid), 0);
        end
        in_valid = 1'b0;
        run_block(0, 0, 0, 1'b0, 1'b0, "R5 integer phase");
        run_block(2, 2, 2, 1'b0, 1'b0, "R4 half-half");
        run_block(1, 3, 1, 1'b0, 1'b0, "R7 clip checker");
        run_block(3, 1, 1, 1'b0, 1'b0, "R3 clip checker");
        run_block(3, 1, 2, 1'b1, 1'b0, "R10 gaps");
        run_block(1, 2, 2, 1'b0, 1'b1, "R8 phase wiggle");
        run_block(2, 0, 0, 1'b1, 1'b0, "R9 next block");
        repeat (5) @(negedge clk);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule